// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider with Reference Divider

This block holds the two programmable dividers that feed the phase detector of a frequency synthesizer. The feedback side models a two-modulus prescaler that divides by P+1 or by P, together with a 7-bit swallow count A and an 11-bit main count B. One full division cycle takes P·B + A input clocks. The base modulus P is 64 or 128, picked by one select bit. The reference side divides its own oscillator clock by a 14-bit ratio R. Each side emits a single-cycle pulse at the end of every division cycle. The loop therefore settles where f_vco = (P·B + A)·f_ref / R.

The feedback divider is a state machine with three states. FB_LOAD is entered from reset. It takes the first settings and moves to FB_SWALLOW when A is nonzero, and to FB_MAIN otherwise. FB_SWALLOW divides by P+1. When the A-th prescaler period ends it moves to FB_MAIN, which divides by P. When the B-th prescaler period ends, in either state, the terminal-count transition reloads all settings and goes to FB_SWALLOW or FB_MAIN, using the same rule as FB_LOAD. The reference divider has two states. RD_LOAD takes the first ratio and moves to RD_COUNT. RD_COUNT stays in RD_COUNT and reloads the ratio at each terminal count. Settings are sampled only at these load and reload edges. Illegal settings are clamped to the nearest legal value and flagged.

Top module: `dual_mod_divider`

## Requirements
- R1: With P, A and B legal and held, fb_pulse is high for one vco_clk cycle once every P·B + A vco_clk cycles.
- R2: cfg_sel128 = 0 selects P = 64, and cfg_sel128 = 1 selects P = 128.
- R3: fb_mod_hi is high for the first (P+1)·A vco_clk cycles of each division cycle, counting the cycle that follows the load or reload edge as the first. It is low for the rest of the cycle. When A = 0 it never goes high.
- R4: With cfg_r legal and held, ref_pulse is high for one ref_clk cycle once every R ref_clk cycles.
- R5: cfg_a, cfg_b, cfg_sel128 and cfg_r are sampled only at the edge that starts a division cycle. That edge is the first edge after reset, or the edge on which the pulse is raised. A change at any other time leaves the current cycle untouched. fb_err and ref_err change only at those edges.
- R6: A cfg_b value below 3 is treated as 3 and sets fb_err to 1 for that division cycle.
- R7: A cfg_a value greater than the (clamped) B is treated as equal to B and sets fb_err to 1 for that division cycle. fb_err is 0 when both A and B are legal.
- R8: A cfg_r value below 3 is treated as 3 and sets ref_err to 1 for that division cycle. ref_err is 0 otherwise.
- R9: While a reset is high, every output of its domain is 0. The first edge with reset low loads the settings. The first pulse follows exactly one division cycle after that edge.
- R10: Neither pulse output is ever high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Prescaler-side input clock |
| vco_rst | input | 1 | Synchronous reset of the feedback side, active high |
| ref_clk | input | 1 | Reference oscillator clock |
| ref_rst | input | 1 | Synchronous reset of the reference side, active high |
| cfg_a | input | 7 | Swallow count A |
| cfg_b | input | 11 | Main count B |
| cfg_sel128 | input | 1 | Prescaler base select: 0 = 64, 1 = 128 |
| cfg_r | input | 14 | Reference ratio R |
| fb_pulse | output | 1 | One-cycle pulse per feedback division cycle |
| fb_mod_hi | output | 1 | Modulus control: high while the prescaler divides by P+1 |
| fb_err | output | 1 | Running feedback setting was clamped |
| ref_pulse | output | 1 | One-cycle pulse per reference division cycle |
| ref_err | output | 1 | Running reference ratio was clamped |

## Verification
The assertions assume that each reset is synchronous to its own clock and is held across at least one edge. Beyond that, they assume nothing about the settings. Clamping bounds the pulse spacing from below for any input value, so the bench may change the settings at any negative edge, including illegal values and changes in the middle of a cycle. The bench drives both clocks from one source so that its model can run both domains on one edge. The assertions never depend on the two clocks being related.

// File: rtl/dual_mod_divider_pkg.sv
package dual_mod_divider_pkg;

    typedef enum logic [1:0] {
        FB_LOAD    = 2'd0,
        FB_SWALLOW = 2'd1,
        FB_MAIN    = 2'd2
    } fb_state_t;

    typedef enum logic {
        RD_LOAD  = 1'b0,
        RD_COUNT = 1'b1
    } rd_state_t;

endpackage

// File: rtl/swallow_divider.sv
module swallow_divider
    import dual_mod_divider_pkg::*;
#(
    parameter int A_W   = 7,
    parameter int B_W   = 11,
    parameter int P_LOW = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    input  logic           cfg_sel,
    output logic           div_pulse,
    output logic           mod_hi,
    output logic           cfg_err
);
    localparam int PC_W = $clog2(2 * P_LOW + 1);
    localparam logic [PC_W-1:0] PRE_LO = PC_W'(P_LOW);
    localparam logic [PC_W-1:0] PRE_HI = PC_W'(2 * P_LOW);
    localparam logic [B_W-1:0]  B_MIN  = B_W'(3);

    fb_state_t      state, nxt, start_st;
    logic [PC_W-1:0] pre_cnt, p_new, p_cur;
    logic [A_W-1:0]  a_rem, a_fix;
    logic [B_W-1:0]  b_rem, b_fix, a_ext;
    logic            sel_cur, err_in, tick, last_tick;

    // clamp incoming settings to the legal range
    always_comb begin
        a_ext = B_W'(cfg_a);
        b_fix = (cfg_b < B_MIN) ? B_MIN : cfg_b;
        if (a_ext > b_fix) a_fix = b_fix[A_W-1:0];
        else               a_fix = cfg_a;
        err_in   = (cfg_b < B_MIN) || (a_ext > b_fix);
        p_new    = cfg_sel ? PRE_HI : PRE_LO;
        p_cur    = sel_cur ? PRE_HI : PRE_LO;
        start_st = (a_fix != '0) ? FB_SWALLOW : FB_MAIN;
    end

    assign tick      = (pre_cnt == '0);
    assign last_tick = tick && (b_rem == B_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            FB_LOAD:    nxt = start_st;
            FB_SWALLOW: begin
                if (last_tick)                         nxt = start_st;
                else if (tick && (a_rem == A_W'(1)))   nxt = FB_MAIN;
            end
            FB_MAIN:    if (last_tick) nxt = start_st;
            default:    nxt = FB_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FB_LOAD;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt   <= '0;
            a_rem     <= '0;
            b_rem     <= '0;
            sel_cur   <= 1'b0;
            cfg_err   <= 1'b0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= 1'b0;
            if ((state == FB_LOAD) || last_tick) begin
                a_rem     <= a_fix;
                b_rem     <= b_fix;
                sel_cur   <= cfg_sel;
                cfg_err   <= err_in;
                pre_cnt   <= (a_fix != '0) ? p_new : p_new - 1'b1;
                div_pulse <= (state != FB_LOAD);
            end else if (tick) begin
                b_rem <= b_rem - 1'b1;
                if (state == FB_SWALLOW) a_rem <= a_rem - 1'b1;
                pre_cnt <= (nxt == FB_SWALLOW) ? p_cur : p_cur - 1'b1;
            end else begin
                pre_cnt <= pre_cnt - 1'b1;
            end
        end
    end

    assign mod_hi = (state == FB_SWALLOW);

endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import dual_mod_divider_pkg::*;
#(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] cfg_r,
    output logic           div_pulse,
    output logic           cfg_err
);
    localparam logic [R_W-1:0] R_MIN = R_W'(3);

    rd_state_t      state, nxt;
    logic [R_W-1:0] r_cnt, r_fix;
    logic           err_in;

    always_comb begin
        r_fix  = (cfg_r < R_MIN) ? R_MIN : cfg_r;
        err_in = (cfg_r < R_MIN);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_LOAD:  nxt = RD_COUNT;
            RD_COUNT: nxt = RD_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RD_LOAD;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cnt     <= '0;
            cfg_err   <= 1'b0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= 1'b0;
            if ((state == RD_LOAD) || (r_cnt == '0)) begin
                r_cnt     <= r_fix - 1'b1;
                cfg_err   <= err_in;
                div_pulse <= (state == RD_COUNT);
            end else begin
                r_cnt <= r_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
    parameter int A_W   = 7,
    parameter int B_W   = 11,
    parameter int R_W   = 14,
    parameter int P_LOW = 64
) (
    input  logic           vco_clk,
    input  logic           vco_rst,
    input  logic           ref_clk,
    input  logic           ref_rst,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    input  logic           cfg_sel128,
    input  logic [R_W-1:0] cfg_r,
    output logic           fb_pulse,
    output logic           fb_mod_hi,
    output logic           fb_err,
    output logic           ref_pulse,
    output logic           ref_err
);

    swallow_divider #(.A_W(A_W), .B_W(B_W), .P_LOW(P_LOW)) u_fb (
        .clk       (vco_clk),
        .rst       (vco_rst),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .cfg_sel   (cfg_sel128),
        .div_pulse (fb_pulse),
        .mod_hi    (fb_mod_hi),
        .cfg_err   (fb_err)
    );

    ref_divider #(.R_W(R_W)) u_ref (
        .clk       (ref_clk),
        .rst       (ref_rst),
        .cfg_r     (cfg_r),
        .div_pulse (ref_pulse),
        .cfg_err   (ref_err)
    );

endmodule

// File: rtl/dual_mod_divider_chk.sv
module dual_mod_divider_chk #(
    parameter int P_LOW = 64
) (
    input logic vco_clk,
    input logic vco_rst,
    input logic ref_clk,
    input logic ref_rst,
    input logic fb_pulse,
    input logic fb_mod_hi,
    input logic fb_err,
    input logic ref_pulse,
    input logic ref_err
);
    localparam int GAP_W = 16;
    localparam logic [GAP_W-1:0] FB_GAP_MIN  = GAP_W'(3 * P_LOW - 1);
    localparam logic [GAP_W-1:0] REF_GAP_MIN = GAP_W'(2);

    logic v_run1, v_run2, r_run1, r_run2;
    logic [GAP_W-1:0] fb_gap, ref_gap;

    always_ff @(posedge vco_clk) begin
        if (vco_rst) begin
            v_run1 <= 1'b0;
            v_run2 <= 1'b0;
            fb_gap <= '0;
        end else begin
            v_run1 <= 1'b1;
            v_run2 <= v_run1;
            if (fb_pulse)          fb_gap <= '0;
            else if (fb_gap != '1) fb_gap <= fb_gap + 1'b1;
        end
    end

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            r_run1  <= 1'b0;
            r_run2  <= 1'b0;
            ref_gap <= '0;
        end else begin
            r_run1 <= 1'b1;
            r_run2 <= r_run1;
            if (ref_pulse)          ref_gap <= '0;
            else if (ref_gap != '1) ref_gap <= ref_gap + 1'b1;
        end
    end

    AST_FB_PULSE_ONE_CYCLE: assert property (@(posedge vco_clk) disable iff (vco_rst)
        fb_pulse |=> !fb_pulse);                                        // R10
    AST_REF_PULSE_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ref_pulse |=> !ref_pulse);                                      // R10
    AST_FB_GAP_MIN: assert property (@(posedge vco_clk) disable iff (vco_rst)
        fb_pulse |-> (fb_gap >= FB_GAP_MIN));                           // R6
    AST_REF_GAP_MIN: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ref_pulse |-> (ref_gap >= REF_GAP_MIN));                        // R8
    AST_MODHI_RISE_AT_RELOAD: assert property (@(posedge vco_clk) disable iff (vco_rst)
        (v_run2 && $rose(fb_mod_hi)) |-> fb_pulse);                     // R3
    AST_FB_ERR_AT_RELOAD: assert property (@(posedge vco_clk) disable iff (vco_rst)
        (v_run2 && !$stable(fb_err)) |-> fb_pulse);                     // R5
    AST_REF_ERR_AT_RELOAD: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (r_run2 && !$stable(ref_err)) |-> ref_pulse);                   // R5

endmodule

bind dual_mod_divider dual_mod_divider_chk #(.P_LOW(P_LOW)) u_chk (
    .vco_clk   (vco_clk),
    .vco_rst   (vco_rst),
    .ref_clk   (ref_clk),
    .ref_rst   (ref_rst),
    .fb_pulse  (fb_pulse),
    .fb_mod_hi (fb_mod_hi),
    .fb_err    (fb_err),
    .ref_pulse (ref_pulse),
    .ref_err   (ref_err)
);

// File: tb/dual_mod_divider_bench.sv
module dual_mod_divider_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  cfg_a;
    logic [10:0] cfg_b;
    logic        cfg_sel;
    logic [13:0] cfg_r;
    logic        fb_pulse, fb_mod_hi, fb_err, ref_pulse, ref_err;

    always #4 clk = ~clk;   // 125 MHz

    dual_mod_divider u_dual_mod_divider (
        .vco_clk    (clk),
        .vco_rst    (rst),
        .ref_clk    (clk),
        .ref_rst    (rst),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .cfg_sel128 (cfg_sel),
        .cfg_r      (cfg_r),
        .fb_pulse   (fb_pulse),
        .fb_mod_hi  (fb_mod_hi),
        .fb_err     (fb_err),
        .ref_pulse  (ref_pulse),
        .ref_err    (ref_err)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;
    string tag = "R9";

    // behavioural reference model
    int m_phase = 0, m_cnt = 0, m_n = 0, m_swal = 0;
    int e_fbp = 0, e_mod = 0, e_ferr = 0;
    int r_phase = 0, r_cnt = 0, r_n = 0;
    int e_refp = 0, e_rerr = 0;
    int fb_last = -1, fb_prev = -1, rf_last = -1, rf_prev = -1;

    task automatic fb_latch();
        int b, a, p;
        b = (cfg_b < 3) ? 3 : int'(cfg_b);
        a = (int'(cfg_a) > b) ? b : int'(cfg_a);
        p = cfg_sel ? 128 : 64;
        m_n    = p * b + a;
        m_swal = (p + 1) * a;
        e_ferr = ((cfg_b < 3) || (int'(cfg_a) > b)) ? 1 : 0;
    endtask

    task automatic rf_latch();
        r_n    = (cfg_r < 3) ? 3 : int'(cfg_r);
        e_rerr = (cfg_r < 3) ? 1 : 0;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_phase = 0; e_fbp = 0; e_mod = 0; e_ferr = 0;
            r_phase = 0; e_refp = 0; e_rerr = 0;
        end else begin
            if (m_phase == 0) begin
                fb_latch(); m_phase = 1; m_cnt = 0; e_fbp = 0;
            end else begin
                m_cnt = m_cnt + 1;
                if (m_cnt == m_n) begin
                    fb_latch(); m_cnt = 0; e_fbp = 1;
                end else e_fbp = 0;
            end
            e_mod = (m_cnt < m_swal) ? 1 : 0;
            if (r_phase == 0) begin
                rf_latch(); r_phase = 1; r_cnt = 0; e_refp = 0;
            end else begin
                r_cnt = r_cnt + 1;
                if (r_cnt == r_n) begin
                    rf_latch(); r_cnt = 0; e_refp = 1;
                end else e_refp = 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(tag, "fb_pulse (R1/R10)", int'(fb_pulse), e_fbp);
            chk(tag, "fb_mod_hi (R3)",    int'(fb_mod_hi), e_mod);
            chk(tag, "fb_err (R6/R7)",    int'(fb_err), e_ferr);
            chk(tag, "ref_pulse (R4)",    int'(ref_pulse), e_refp);
            chk(tag, "ref_err (R8)",      int'(ref_err), e_rerr);
            if (fb_pulse)  begin fb_prev = fb_last; fb_last = cyc; end
            if (ref_pulse) begin rf_prev = rf_last; rf_last = cyc; end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        if (cyc == 190000 && !done) begin
            done = 1;
            failures = failures + 1;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setcfg(int sel, int a, int b, int r);
        @(negedge clk);
        cfg_sel = sel[0];
        cfg_a   = a[6:0];
        cfg_b   = b[10:0];
        cfg_r   = r[13:0];
    endtask

    task automatic period_fb(string req, int exp);
        chk(req, "fb period", fb_last - fb_prev, exp);
    endtask

    task automatic period_ref(string req, int exp);
        chk(req, "ref period", rf_last - rf_prev, exp);
    endtask

    int lfsr = 32'h1D3A;
    task automatic step_lfsr();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    endtask

    initial begin
        rst = 1'b1; cfg_sel = 1'b0; cfg_a = 7'd5; cfg_b = 11'd7; cfg_r = 14'd10;
        run(2);
        cmp_on = 1;
        tag = "R9";
        run(3);
        chk("R9", "fb_pulse in reset", int'(fb_pulse), 0);
        chk("R9", "fb_mod_hi in reset", int'(fb_mod_hi), 0);
        chk("R9", "ref_pulse in reset", int'(ref_pulse), 0);
        rst = 1'b0;
        tag = "R1";
        run(1000);
        period_fb("R1", 453);
        period_ref("R4", 10);

        tag = "R2";                       // mid-cycle change, P = 128
        setcfg(1, 3, 4, 7);
        run(1600);
        period_fb("R2", 515);
        period_ref("R4", 7);

        tag = "R3";                       // A = 0: modulus control never high
        setcfg(0, 0, 3, 9);
        run(700);
        period_fb("R3", 192);
        setcfg(0, 6, 6, 9);               // A = B
        run(1000);
        period_fb("R3", 390);

        tag = "R6";                       // B below 3
        setcfg(0, 0, 1, 1);
        run(600);
        period_fb("R6", 192);
        chk("R6", "fb_err set", int'(fb_err), 1);
        period_ref("R8", 3);
        chk("R8", "ref_err set", int'(ref_err), 1);

        tag = "R7";                       // A above B
        setcfg(0, 9, 4, 0);
        run(800);
        period_fb("R7", 260);
        chk("R7", "fb_err set", int'(fb_err), 1);
        period_ref("R8", 3);

        tag = "R8";                       // back to legal values
        setcfg(1, 2, 5, 5);
        run(1500);
        chk("R7", "fb_err clear", int'(fb_err), 0);
        chk("R8", "ref_err clear", int'(ref_err), 0);
        period_fb("R2", 642);
        period_ref("R4", 5);

        tag = "R5";                       // frequent changes at arbitrary times
        for (int i = 0; i < 80; i++) begin
            step_lfsr();
            setcfg(lfsr & 1, (lfsr >> 1) % 12, (lfsr >> 5) % 9, (lfsr >> 9) % 20);
            run(((lfsr >> 3) % 50) + 1);
        end

        tag = "R9";                       // reset in the middle of a cycle
        @(negedge clk); rst = 1'b1;
        run(3);
        chk("R9", "fb_pulse held low", int'(fb_pulse), 0);
        chk("R9", "fb_err held low", int'(fb_err), 0);
        setcfg(0, 1, 3, 4);
        rst = 1'b0;
        run(700);
        period_fb("R9", 193);
        period_ref("R9", 4);

        done = 1;
        summary();
        $finish;
    end

endmodule